// File: doc/BRIEF.md
# Control-Register Access Gate and Write Merger

This block sits beside the execute stage of a processor pipeline and judges every control-register access before any register changes. The execute stage gives it a 12-bit register address, the current privilege level, a write-data word and a write-mask word. The gate also receives the current value of the addressed register from the register file, the floating-point state field of the status register, both counter-enable words, and a flag that says whether the supervisor extension is present. The gate returns an illegal-access flag, a write strobe, the value to write back, and the value the instruction reads.

The gate takes the legality rules from the address itself: bits [9:8] give the lowest privilege allowed, and bits [11:10] equal to 3 mark a read-only register. Some groups of registers have extra predicates. User counters depend on the counter enables for the current mode. Floating-point registers are blocked while the floating-point unit is off. Supervisor registers are blocked when the supervisor extension is absent. The set of implemented addresses is decoded inside the block. Every other address is illegal.

All four CSR instruction forms go through one merge: new = (old AND NOT mask) OR (data AND mask). A plain read is data 0 with mask 0. A read-write is mask all-ones with data rs1. A read-set is data all-ones with mask rs1. A read-clear is data 0 with mask rs1. The gate is purely combinational, so it answers in the same cycle as the request.

Top module: `csr_access_gate`

## Requirements
- R1: An access is illegal when the privilege input (U=0, S=1, M=3) is numerically below address bits [9:8].
- R2: When address bits [11:10] equal 3, any access with a nonzero write mask is illegal. A read of such an address with mask 0 is legal if no other rule forbids it.
- R3: With XLEN=32, these addresses are implemented: 0x001–0x003; 0xC00 and 0xC02–0xC1F; 0xC80 and 0xC82–0xC9F; 0xB00 and 0xB02–0xB1F; 0xB80 and 0xB82–0xB9F; 0x323–0x33F; 0xF11–0xF14; 0x300–0x306; 0x340–0x344; 0x100; 0x104–0x106; 0x140–0x144; 0x180. Any other address is illegal. The upper-half counter ranges 0xC80–0xC9F and 0xB80–0xB9F exist only when XLEN is 32.
- R4: The write data equals (old AND NOT mask) OR (data AND mask). The write strobe is high only when the access is legal and the mask is nonzero.
- R5: The read data equals the old value on a legal access and 0 on an illegal one.
- R6: For the user counters 0xC00–0xC1F and 0xC80–0xC9F, U mode needs bit addr[4:0] of the supervisor counter-enable word, S mode needs the same bit of the machine counter-enable word, and M mode is always allowed.
- R7: Addresses 0x001, 0x002 and 0x003 are illegal while the floating-point state input is 0.
- R8: A strobed write to 0x001–0x003 raises the dirty output, which tells the status register to set its floating-point state field to 3. The write data is cut down to 5 bits at 0x001 (flags), 3 bits at 0x002 (rounding mode), and 8 bits at 0x003, where the rounding mode sits in [7:5] and the flags in [4:0].
- R9: Implemented addresses with bits [9:8] equal to 1 are illegal when the supervisor extension input is 0.
- R10: The illegal flag and the write strobe are never high together.
- R11: Read-set with data all-ones writes old OR rs1. Read-clear with data 0 writes old AND NOT rs1. Read-write with mask all-ones writes rs1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 12 | Register address of the access |
| priv_i | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| wdata_i | input | XLEN | Write data operand |
| wmask_i | input | XLEN | Write mask operand |
| old_i | input | XLEN | Current contents of the addressed register |
| fs_i | input | 2 | Floating-point state field of the status register |
| scnt_en_i | input | 32 | Supervisor counter-enable word |
| mcnt_en_i | input | 32 | Machine counter-enable word |
| s_ext_i | input | 1 | Supervisor extension present |
| illegal_o | output | 1 | Access is illegal |
| wr_en_o | output | 1 | Write strobe for the register file |
| wr_data_o | output | XLEN | Merged value to write |
| rd_data_o | output | XLEN | Value returned to the destination register |
| fs_dirty_o | output | 1 | Set the floating-point state field to dirty (3) |

## Verification
The assertions assume the privilege input holds only 0, 1 or 3. They also assume that each input word stays fixed for the whole evaluation of one request, because every check relates outputs to the inputs of that same request. The stimulus only drives the three legal privilege codes. It changes all inputs together on one clock edge and samples a half period later, so every comparison sees settled combinational outputs. The main sweep covers all 4096 addresses with a zero and a nonzero mask. Focused sweeps then switch the floating-point state, the extension flag and the counter enables one at a time.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

    localparam int ADDR_W   = 12;
    localparam int CNT_N    = 32;
    localparam int CNT_IW   = $clog2(CNT_N);
    localparam int FLAGS_W  = 5;
    localparam int RM_W     = 3;
    localparam int FPALL_W  = FLAGS_W + RM_W;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_FP_FLAGS,
        CLS_FP_RM,
        CLS_FP_ALL,
        CLS_UCNT,
        CLS_PLAIN
    } csr_cls_e;

    typedef struct packed {
        logic       impl;
        csr_cls_e   cls;
        logic [1:0] min_priv;
        logic       ro;
        logic       sup;
    } csr_attr_t;

    function automatic logic is_fp(csr_cls_e c);
        return (c == CLS_FP_FLAGS) || (c == CLS_FP_RM) || (c == CLS_FP_ALL);
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_gate_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    output csr_attr_t         attr_o
);

    logic       hi_en;
    logic [6:0] blk;
    logic [4:0] idx;
    csr_cls_e   cls_d;

    // Upper-half counter aliases exist only on a 32-bit datapath
    generate
        if (XLEN == 32) begin : g_hi_half
            assign hi_en = 1'b1;
        end else begin : g_no_hi_half
            assign hi_en = 1'b0;
        end
    endgenerate

    assign blk = addr_i[11:5];
    assign idx = addr_i[4:0];

    always_comb begin
        cls_d = CLS_NONE;
        if (addr_i == 12'h001) begin
            cls_d = CLS_FP_FLAGS;
        end else if (addr_i == 12'h002) begin
            cls_d = CLS_FP_RM;
        end else if (addr_i == 12'h003) begin
            cls_d = CLS_FP_ALL;
        end else if ((blk == 7'h60 || (blk == 7'h64 && hi_en)) && idx != 5'd1) begin
            cls_d = CLS_UCNT;          // user counters, slot 1 absent
        end else if ((blk == 7'h58 || (blk == 7'h5C && hi_en)) && idx != 5'd1) begin
            cls_d = CLS_PLAIN;         // machine counters
        end else if (blk == 7'h19 && idx >= 5'd3) begin
            cls_d = CLS_PLAIN;         // machine event selectors
        end else if ((addr_i >= 12'hF11 && addr_i <= 12'hF14) ||
                     (addr_i >= 12'h300 && addr_i <= 12'h306) ||
                     (addr_i >= 12'h340 && addr_i <= 12'h344) ||
                     (addr_i == 12'h100) ||
                     (addr_i >= 12'h104 && addr_i <= 12'h106) ||
                     (addr_i >= 12'h140 && addr_i <= 12'h144) ||
                     (addr_i == 12'h180)) begin
            cls_d = CLS_PLAIN;
        end
    end

    always_comb begin
        attr_o.cls      = cls_d;
        attr_o.impl     = (cls_d != CLS_NONE);
        attr_o.min_priv = addr_i[9:8];
        attr_o.ro       = (addr_i[11:10] == 2'b11);
        attr_o.sup      = (addr_i[9:8] == 2'b01);
    end

endmodule

// File: rtl/csr_priv_gate.sv
module csr_priv_gate
    import csr_gate_pkg::*;
(
    input  csr_attr_t        attr_i,
    input  logic [CNT_IW-1:0] idx_i,
    input  logic [1:0]       priv_i,
    input  logic             wmask_nz_i,
    input  logic [1:0]       fs_i,
    input  logic [CNT_N-1:0] scnt_en_i,
    input  logic [CNT_N-1:0] mcnt_en_i,
    input  logic             s_ext_i,
    output logic             illegal_o
);

    logic cnt_ok;
    logic fp_off;
    logic below_floor;
    logic ro_write;
    logic sup_absent;

    always_comb begin
        cnt_ok = 1'b1;
        if (attr_i.cls == CLS_UCNT) begin
            case (priv_i)
                PRIV_U:  cnt_ok = scnt_en_i[idx_i];
                PRIV_S:  cnt_ok = mcnt_en_i[idx_i];
                default: cnt_ok = 1'b1;
            endcase
        end
        fp_off      = is_fp(attr_i.cls) && (fs_i == 2'b00);
        below_floor = (priv_i < attr_i.min_priv);
        ro_write    = attr_i.ro && wmask_nz_i;
        sup_absent  = attr_i.sup && !s_ext_i;
        illegal_o   = !attr_i.impl || below_floor || ro_write ||
                      fp_off || !cnt_ok || sup_absent;
    end

    // Counter gating: an unimplemented-free user counter in U mode follows the supervisor enable
    always_comb begin
        assert_cnt_user_R6: assert (!(attr_i.cls == CLS_UCNT && priv_i == PRIV_U &&
                                      !scnt_en_i[idx_i]) || illegal_o);
        assert_sup_absent_R9: assert (!(attr_i.sup && !s_ext_i) || illegal_o);
    end

endmodule

// File: rtl/csr_merge.sv
module csr_merge
    import csr_gate_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_cls_e          cls_i,
    input  logic [XLEN-1:0]   old_i,
    input  logic [XLEN-1:0]   wdata_i,
    input  logic [XLEN-1:0]   wmask_i,
    output logic [XLEN-1:0]   merged_o
);

    logic [XLEN-1:0] raw;

    always_comb begin
        raw      = (old_i & ~wmask_i) | (wdata_i & wmask_i);
        merged_o = raw;
        case (cls_i)
            CLS_FP_FLAGS: merged_o = {{(XLEN-FLAGS_W){1'b0}}, raw[FLAGS_W-1:0]};
            CLS_FP_RM:    merged_o = {{(XLEN-RM_W){1'b0}},    raw[RM_W-1:0]};
            CLS_FP_ALL:   merged_o = {{(XLEN-FPALL_W){1'b0}}, raw[FPALL_W-1:0]};
            default:      merged_o = raw;
        endcase
    end

    // Unmasked bits of an ordinary register keep their old value
    always_comb begin
        assert_keep_unmasked_R4: assert (is_fp(cls_i) ||
                                         (((merged_o ^ old_i) & ~wmask_i) == '0));
    end

endmodule

// File: rtl/csr_access_gate.sv
module csr_access_gate
    import csr_gate_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [11:0]     addr_i,
    input  logic [1:0]      priv_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [XLEN-1:0] wmask_i,
    input  logic [XLEN-1:0] old_i,
    input  logic [1:0]      fs_i,
    input  logic [31:0]     scnt_en_i,
    input  logic [31:0]     mcnt_en_i,
    input  logic            s_ext_i,
    output logic            illegal_o,
    output logic            wr_en_o,
    output logic [XLEN-1:0] wr_data_o,
    output logic [XLEN-1:0] rd_data_o,
    output logic            fs_dirty_o
);

    typedef struct packed {
        logic            illegal;
        logic            wr_en;
        logic            fs_dirty;
        logic [XLEN-1:0] wr_data;
        logic [XLEN-1:0] rd_data;
    } gate_out_t;

    csr_attr_t       attr;
    logic            illegal;
    logic            wmask_nz;
    logic [XLEN-1:0] merged;
    gate_out_t       out_d;

    assign wmask_nz = |wmask_i;

    csr_addr_decode #(.XLEN(XLEN)) i_decode (
        .addr_i (addr_i),
        .attr_o (attr)
    );

    csr_priv_gate i_gate (
        .attr_i     (attr),
        .idx_i      (addr_i[CNT_IW-1:0]),
        .priv_i     (priv_i),
        .wmask_nz_i (wmask_nz),
        .fs_i       (fs_i),
        .scnt_en_i  (scnt_en_i),
        .mcnt_en_i  (mcnt_en_i),
        .s_ext_i    (s_ext_i),
        .illegal_o  (illegal)
    );

    csr_merge #(.XLEN(XLEN)) i_merge (
        .cls_i    (attr.cls),
        .old_i    (old_i),
        .wdata_i  (wdata_i),
        .wmask_i  (wmask_i),
        .merged_o (merged)
    );

    always_comb begin
        out_d          = '0;
        out_d.illegal  = illegal;
        out_d.wr_en    = !illegal && wmask_nz;
        out_d.fs_dirty = out_d.wr_en && is_fp(attr.cls);
        out_d.wr_data  = merged;
        out_d.rd_data  = illegal ? '0 : old_i;
    end

    assign illegal_o  = out_d.illegal;
    assign wr_en_o    = out_d.wr_en;
    assign fs_dirty_o = out_d.fs_dirty;
    assign wr_data_o  = out_d.wr_data;
    assign rd_data_o  = out_d.rd_data;

    always_comb begin
        assert_excl_R10:     assert (!(illegal_o && wr_en_o));
        assert_floor_R1:     assert (!(priv_i < addr_i[9:8]) || illegal_o);
        assert_ro_R2:        assert (!(addr_i[11:10] == 2'b11 && wmask_i != '0) || illegal_o);
        assert_fp_off_R7:    assert (!(addr_i >= 12'h001 && addr_i <= 12'h003 && fs_i == 2'b00)
                                     || illegal_o);
        assert_dirty_R8:     assert (!fs_dirty_o || (wr_en_o && addr_i[11:2] == '0));
        assert_rd_old_R5:    assert (illegal_o || rd_data_o == old_i);
        assert_strobe_R4:    assert (!wr_en_o || wmask_i != '0);
    end

endmodule

// File: tb/test_csr_access_gate.sv
`timescale 1ns/1ps
module test_csr_access_gate;

    localparam int XLEN = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [11:0]     addr;
    logic [1:0]      priv;
    logic [XLEN-1:0] wdata, wmask, old;
    logic [1:0]      fs;
    logic [31:0]     scen, mcen;
    logic            sx;
    logic            illegal, wr_en, fs_dirty;
    logic [XLEN-1:0] wr_data, rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    csr_access_gate #(.XLEN(XLEN)) i_csr_access_gate (
        .addr_i     (addr),
        .priv_i     (priv),
        .wdata_i    (wdata),
        .wmask_i    (wmask),
        .old_i      (old),
        .fs_i       (fs),
        .scnt_en_i  (scen),
        .mcnt_en_i  (mcen),
        .s_ext_i    (sx),
        .illegal_o  (illegal),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .rd_data_o  (rd_data),
        .fs_dirty_o (fs_dirty)
    );

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s addr=%03h priv=%0d actual=%08h expected=%08h",
                     req, what, addr, priv, got, exp);
        end
    endtask

    task automatic apply(int a, int p, logic [31:0] d, logic [31:0] m, logic [31:0] o,
                         logic [1:0] f, logic [31:0] se, logic [31:0] me, logic s);
        @(posedge clk);
        addr = a[11:0]; priv = p[1:0]; wdata = d; wmask = m; old = o;
        fs = f; scen = se; mcen = me; sx = s;
        @(negedge clk);
    endtask

    function automatic bit in_rng(int a, int lo, int hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic bit m_impl(int a);
        int lo5 = a & 31;
        if (in_rng(a, 1, 3)) return 1;
        if (in_rng(a, 'hC00, 'hC1F) || in_rng(a, 'hC80, 'hC9F)) return lo5 != 1;
        if (in_rng(a, 'hB00, 'hB1F) || in_rng(a, 'hB80, 'hB9F)) return lo5 != 1;
        if (in_rng(a, 'h323, 'h33F) || in_rng(a, 'hF11, 'hF14)) return 1;
        if (in_rng(a, 'h300, 'h306) || in_rng(a, 'h340, 'h344)) return 1;
        if (a == 'h100 || a == 'h180 || in_rng(a, 'h104, 'h106) || in_rng(a, 'h140, 'h144))
            return 1;
        return 0;
    endfunction

    function automatic bit m_illegal();
        int  a    = int'(addr);
        int  p    = int'(priv);
        int  need = (a >> 8) & 3;
        bit  bad  = 0;
        bit  ucnt = in_rng(a, 'hC00, 'hC1F) || in_rng(a, 'hC80, 'hC9F);
        if (!m_impl(a)) bad = 1;
        if (p < need) bad = 1;
        if (((a >> 10) == 3) && wmask != 0) bad = 1;
        if (in_rng(a, 1, 3) && fs == 0) bad = 1;
        if (ucnt && p == 0 && !scen[a & 31]) bad = 1;
        if (ucnt && p == 1 && !mcen[a & 31]) bad = 1;
        if (need == 1 && !sx) bad = 1;
        return bad;
    endfunction

    function automatic logic [31:0] m_wr_data();
        logic [31:0] v = (old & ~wmask) | (wdata & wmask);
        if (addr == 12'h001) v = v & 32'h1F;
        if (addr == 12'h002) v = v & 32'h07;
        if (addr == 12'h003) v = v & 32'hFF;
        return v;
    endfunction

    task automatic check_all(string tag);
        bit e_ill = m_illegal();
        bit e_wr  = !e_ill && (wmask != 0);
        chk(tag, "illegal", {31'd0, illegal}, {31'd0, e_ill});
        chk("R4 R10", "wr_en", {31'd0, wr_en}, {31'd0, e_wr});
        chk("R5", "rd_data", rd_data, e_ill ? 32'd0 : old);
        if (e_wr) chk("R4 R8", "wr_data", wr_data, m_wr_data());
        chk("R8", "fs_dirty", {31'd0, fs_dirty}, {31'd0, e_wr && addr >= 1 && addr <= 3});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Quiescent inputs: address 0 is not implemented (R3)
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R3", "idle illegal", {31'd0, illegal}, 32'd1);
        chk("R3", "idle wr_en", {31'd0, wr_en}, 32'd0);
        chk("R5", "idle rd_data", rd_data, 32'd0);

        // Full address sweep: R1 R2 R3 R6 R9
        for (int a = 0; a < 4096; a++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int mi = 0; mi < 2; mi++) begin
                    apply(a, (pi == 2) ? 3 : pi, 32'h1234_5678,
                          (mi == 0) ? 32'h0 : 32'h0F0F_F0F0, 32'hA5C3_0F96, 2'd2,
                          32'h5555_5555, 32'h0F0F_0F0F, 1'b1);
                    check_all("R1 R2 R3 R6 R9");
                end
            end
        end

        // Floating-point unit off (R7) and write with it on (R8)
        for (int a = 1; a <= 3; a++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int mi = 0; mi < 2; mi++) begin
                    apply(a, (pi == 2) ? 3 : pi, 32'hFFFF_FFFF, (mi == 0) ? 32'h0 : 32'hFFFF_FFFF,
                          32'h0, 2'd0, 32'h0, 32'h0, 1'b1);
                    check_all("R7");
                end
            end
        end
        apply(3, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 2'd1, 32'h0, 32'h0, 1'b0);
        chk("R8", "fcsr width", wr_data, 32'hFF);
        chk("R8", "dirty", {31'd0, fs_dirty}, 32'd1);
        apply(2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 2'd1, 32'h0, 32'h0, 1'b0);
        chk("R8", "frm width", wr_data, 32'h7);
        apply(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 2'd3, 32'h0, 32'h0, 1'b0);
        chk("R8", "fflags width", wr_data, 32'h1F);

        // Supervisor extension absent (R9)
        for (int a = 'h100; a < 'h200; a++) begin
            apply(a, 1, 32'h0, 32'h0, 32'h7777_0000, 2'd2, 32'h0, 32'h0, 1'b0);
            check_all("R9");
            apply(a, 3, 32'h0, 32'h0, 32'h7777_0000, 2'd2, 32'h0, 32'h0, 1'b0);
            check_all("R9");
        end

        // Counter enable walk (R6)
        for (int i = 0; i < 32; i++) begin
            logic [31:0] one = 32'd1 << i;
            apply('hC00 + i, 0, 0, 0, 32'h0000_0042, 2'd2, one, ~one, 1'b1);
            check_all("R6");
            apply('hC00 + i, 0, 0, 0, 32'h0000_0042, 2'd2, ~one, one, 1'b1);
            check_all("R6");
            apply('hC80 + i, 1, 0, 0, 32'h0000_0042, 2'd2, ~one, one, 1'b1);
            check_all("R6");
            apply('hC80 + i, 1, 0, 0, 32'h0000_0042, 2'd2, one, ~one, 1'b1);
            check_all("R6");
            apply('hC00 + i, 3, 0, 0, 32'h0000_0042, 2'd2, 32'h0, 32'h0, 1'b1);
            check_all("R6");
        end

        // Instruction forms on a machine scratch-style register (R11)
        apply('h340, 3, 32'hFFFF_FFFF, 32'h0000_000F, 32'h0000_00F0, 2'd2, 0, 0, 1'b1);
        chk("R11", "set", wr_data, 32'h0000_00FF);
        chk("R11", "set rd", rd_data, 32'h0000_00F0);
        apply('h340, 3, 32'h0, 32'h0000_0030, 32'h0000_00F0, 2'd2, 0, 0, 1'b1);
        chk("R11", "clear", wr_data, 32'h0000_00C0);
        apply('h340, 3, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0000_00F0, 2'd2, 0, 0, 1'b1);
        chk("R11", "swap", wr_data, 32'hDEAD_BEEF);
        apply('h340, 3, 32'h0, 32'h0, 32'h0000_00F0, 2'd2, 0, 0, 1'b1);
        chk("R11", "plain read strobe", {31'd0, wr_en}, 32'd0);
        chk("R11", "plain read data", rd_data, 32'h0000_00F0);

        // Read-only register: read allowed, write refused (R2)
        apply('hF14, 3, 32'h0, 32'h0, 32'h0000_0005, 2'd2, 0, 0, 1'b1);
        chk("R2", "ro read", {31'd0, illegal}, 32'd0);
        chk("R2", "ro read data", rd_data, 32'h0000_0005);
        apply('hF14, 3, 32'h0, 32'h0000_0001, 32'h0000_0005, 2'd2, 0, 0, 1'b1);
        chk("R2", "ro write", {31'd0, illegal}, 32'd1);
        chk("R10", "ro write strobe", {31'd0, wr_en}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule